// File: doc/BRIEF.md
# Clock-Tied Strap Pin Mode Decoder

This block turns two board-level strap pins into control settings for a dual-channel converter front end. The first strap is a plain two-level input. It picks the current-channel amplification: x8 when low and x32 when high. The second strap has four legal connections: ground, supply, the measurement clock, or the inverted measurement clock. Each connection is one of four modes. The active mode sets a 2-bit reference temperature-coefficient trim code, a prescaler select and a voltage-channel enable.

The block runs on a fast system clock. The measurement clock arrives as an ordinary input and is resynchronized together with the straps. The four-state strap is sampled once while the measurement clock is high and once while it is low. Equal samples mean a constant level. Unequal samples mean one of the clock ties, and the phase that read high tells the two apart. A decoded mode must repeat on several consecutive measurement-clock periods before the block accepts it. Each later change of the accepted mode raises a one-cycle strobe.

If the measurement clock stops for a set number of system cycles, the strap is read as a constant level. All outputs are held at their defaults while reset is asserted.

Top module: `msd_strap_decoder`

## Requirements
- R1: While rst_n is low, and after its release until a mode is accepted, tc_trim_o is 00, prescale_div2_o is 0, vch_en_o is 0 and mode_chg_o is 0. During reset gain_x32_o is also 0.
- R2: gain_x32_o follows cfg_gain_i after the SYNC_STAGES synchronizer delay. A value of 0 means x8 amplification and 1 means x32.
- R3: The decoded mode is 0 when cfg_tc_i is tied low, 1 when it is tied to mclk_i, 2 when it is tied to inverted mclk_i, and 3 when it is tied high. tc_trim_o carries the accepted mode as a binary code: 00=100, 01=170, 10=125, 11=190 ppm/°C.
- R4: A mode is accepted only after ACCEPT_N (default 4) consecutive equal per-period decodes. Shorter runs leave the outputs unchanged.
- R5: mode_chg_o pulses high for exactly one cycle in the same cycle that tc_trim_o takes a new accepted value. It is never high otherwise. Accepting mode 0 as the first mode gives no pulse.
- R6: prescale_div2_o is 1 when the accepted mode is 1 or 2, and 0 when it is 0 or 3.
- R7: vch_en_o goes to 1 when the first mode is accepted after reset and stays at 1 until the next reset.
- R8: If mclk_i shows no edge for TIMEOUT system cycles, the block makes one decode per TIMEOUT cycles from the present strap level: low gives mode 0 and high gives mode 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than mclk_i |
| rst_n | input | 1 | Active-low reset, blocks all functions |
| mclk_i | input | 1 | Measurement clock, sampled as data |
| cfg_gain_i | input | 1 | Two-level gain strap |
| cfg_tc_i | input | 1 | Four-state strap (low, high, clock, inverted clock) |
| tc_trim_o | output | 2 | Reference temperature-coefficient trim code |
| gain_x32_o | output | 1 | 1 selects x32 current-channel amplification, 0 selects x8 |
| prescale_div2_o | output | 1 | Clock prescaler select |
| vch_en_o | output | 1 | Voltage-channel enable |
| mode_chg_o | output | 1 | One-cycle strobe when the accepted mode changes |

## Verification
The bench ties the strap to each of the four connections in turn. A design that swapped the phase of the two clock ties would report 125 in place of 170 ppm, and that shows up as a trim mismatch in the scoreboard. Toggling the strap between low and high faster than the qualification window catches a design that accepts early, because a false acceptance raises a strobe that no expected item matches. Stopping the measurement clock checks that the block falls back to a constant-level decode. A design without this fallback keeps its old mode. A reset applied partway through the run must return every output to its default.

// File: rtl/msd_pkg.sv
package msd_pkg;

  typedef enum logic [1:0] {
    MODE_LOW  = 2'd0,
    MODE_CLK  = 2'd1,
    MODE_NCLK = 2'd2,
    MODE_HIGH = 2'd3
  } strap_mode_t;

  // hi: strap level seen in the clock-high phase, lo: level in the clock-low phase
  function automatic strap_mode_t phase_decode(input logic hi, input logic lo);
    case ({hi, lo})
      2'b00:   return MODE_LOW;
      2'b10:   return MODE_CLK;
      2'b01:   return MODE_NCLK;
      default: return MODE_HIGH;
    endcase
  endfunction

  function automatic logic mode_uses_prescale(input strap_mode_t m);
    return (m == MODE_CLK) || (m == MODE_NCLK);
  endfunction

endpackage

// File: rtl/msd_sync.sv
module msd_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  genvar b;
  generate
    for (b = 0; b < WIDTH; b++) begin : g_bit
      logic [STAGES-1:0] chain;
      if (STAGES == 1) begin : g_one
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain <= '0;
          else        chain <= d_i[b];
        end
      end else begin : g_many
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain <= '0;
          else        chain <= {chain[STAGES-2:0], d_i[b]};
        end
      end
      assign q_o[b] = chain[STAGES-1];
    end
  endgenerate

endmodule

// File: rtl/msd_phase_sampler.sv
module msd_phase_sampler
  import msd_pkg::*;
#(
  parameter int TIMEOUT = 1024
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        mclk_s_i,
  input  logic        pin_s_i,
  output logic        dec_valid_o,
  output strap_mode_t dec_mode_o
);

  localparam int CW = (TIMEOUT > 2) ? $clog2(TIMEOUT) : 1;
  localparam logic [CW-1:0] LAST = CW'(TIMEOUT - 1);

  logic          mclk_q;
  logic          have_hi;
  logic          hi_smp;
  logic [CW-1:0] stall_cnt;
  logic          rise, fall;

  assign rise = mclk_s_i & ~mclk_q;
  assign fall = ~mclk_s_i & mclk_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mclk_q      <= 1'b0;
      have_hi     <= 1'b0;
      hi_smp      <= 1'b0;
      stall_cnt   <= '0;
      dec_valid_o <= 1'b0;
      dec_mode_o  <= MODE_LOW;
    end else begin
      mclk_q      <= mclk_s_i;
      dec_valid_o <= 1'b0;
      if (rise || fall) begin
        stall_cnt <= '0;
      end else if (stall_cnt == LAST) begin
        // clock has stopped: read the strap as a constant level
        stall_cnt   <= '0;
        have_hi     <= 1'b0;
        dec_valid_o <= 1'b1;
        dec_mode_o  <= pin_s_i ? MODE_HIGH : MODE_LOW;
      end else begin
        stall_cnt <= stall_cnt + 1'b1;
      end
      if (rise) begin
        hi_smp  <= pin_s_i;
        have_hi <= 1'b1;
      end
      if (fall && have_hi) begin
        dec_valid_o <= 1'b1;
        dec_mode_o  <= phase_decode(hi_smp, pin_s_i);
        have_hi     <= 1'b0;
      end
    end
  end

  AST_DECODE_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid_o |=> !dec_valid_o) else $error("decodes back to back"); // R8

endmodule

// File: rtl/msd_qualifier.sv
module msd_qualifier
  import msd_pkg::*;
#(
  parameter int ACCEPT_N = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        dec_valid_i,
  input  strap_mode_t dec_mode_i,
  output strap_mode_t acc_mode_o,
  output logic        locked_o,
  output logic        chg_o
);

  localparam int NW = $clog2(ACCEPT_N + 1);
  localparam logic [NW-1:0] FULL = NW'(ACCEPT_N);

  strap_mode_t   cand;
  logic [NW-1:0] cnt;
  logic [NW-1:0] nxt_cnt;

  always_comb begin
    if (dec_mode_i != cand) nxt_cnt = NW'(1);
    else if (cnt == FULL)   nxt_cnt = cnt;
    else                    nxt_cnt = cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cand       <= MODE_LOW;
      cnt        <= '0;
      acc_mode_o <= MODE_LOW;
      locked_o   <= 1'b0;
      chg_o      <= 1'b0;
    end else begin
      chg_o <= 1'b0;
      if (dec_valid_i) begin
        cand <= dec_mode_i;
        cnt  <= nxt_cnt;
        if (nxt_cnt == FULL && (!locked_o || dec_mode_i != acc_mode_o)) begin
          acc_mode_o <= dec_mode_i;
          locked_o   <= 1'b1;
          chg_o      <= (dec_mode_i != acc_mode_o);
        end
      end
    end
  end

  AST_STROBE_AFTER_DECODE: assert property (@(posedge clk) disable iff (!rst_n)
    chg_o |-> $past(dec_valid_i)) else $error("strobe without decode"); // R4

endmodule

// File: rtl/msd_strap_decoder.sv
module msd_strap_decoder
  import msd_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int ACCEPT_N    = 4,
  parameter int TIMEOUT     = 1024
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       mclk_i,
  input  logic       cfg_gain_i,
  input  logic       cfg_tc_i,
  output logic [1:0] tc_trim_o,
  output logic       gain_x32_o,
  output logic       prescale_div2_o,
  output logic       vch_en_o,
  output logic       mode_chg_o
);

  localparam int NSYNC = 3;

  logic [NSYNC-1:0] raw, synced;
  logic             dec_valid;
  strap_mode_t      dec_mode;
  strap_mode_t      acc_mode;
  logic             locked;

  assign raw = {cfg_gain_i, cfg_tc_i, mclk_i};

  msd_sync #(.WIDTH(NSYNC), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d_i  (raw),
    .q_o  (synced)
  );

  msd_phase_sampler #(.TIMEOUT(TIMEOUT)) u_sampler (
    .clk        (clk),
    .rst_n      (rst_n),
    .mclk_s_i   (synced[0]),
    .pin_s_i    (synced[1]),
    .dec_valid_o(dec_valid),
    .dec_mode_o (dec_mode)
  );

  msd_qualifier #(.ACCEPT_N(ACCEPT_N)) u_qual (
    .clk        (clk),
    .rst_n      (rst_n),
    .dec_valid_i(dec_valid),
    .dec_mode_i (dec_mode),
    .acc_mode_o (acc_mode),
    .locked_o   (locked),
    .chg_o      (mode_chg_o)
  );

  assign tc_trim_o       = acc_mode;
  assign gain_x32_o      = synced[2];
  assign prescale_div2_o = mode_uses_prescale(acc_mode);
  assign vch_en_o        = locked;

  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    mode_chg_o |=> !mode_chg_o) else $error("strobe longer than one cycle"); // R5

  AST_TRIM_MOVES_WITH_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(tc_trim_o) |-> mode_chg_o) else $error("trim changed silently"); // R5

  AST_VCH_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    vch_en_o |=> vch_en_o) else $error("voltage enable dropped"); // R7

endmodule

// File: tb/sim_msd_strap_decoder.sv
module sim_msd_strap_decoder;

  localparam int CLK_P   = 10;
  localparam int MHALF   = 8;
  localparam int TMO     = 40;
  localparam int SETTLE  = 150;

  logic clk = 0, rst_n = 0, mclk = 0, gain_pin = 0;
  logic mclk_run = 0;
  int   sel = 0;
  logic tc_pin;
  logic [1:0] trim;
  logic gain_x32, presc, vch, chg;

  int checks = 0, errors = 0;
  int exp_q[$];
  int model_mode = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  assign tc_pin = (sel == 0) ? 1'b0 : (sel == 1) ? mclk : (sel == 2) ? ~mclk : 1'b1;

  msd_strap_decoder #(.SYNC_STAGES(2), .ACCEPT_N(4), .TIMEOUT(TMO)) u0 (
    .clk(clk), .rst_n(rst_n), .mclk_i(mclk), .cfg_gain_i(gain_pin), .cfg_tc_i(tc_pin),
    .tc_trim_o(trim), .gain_x32_o(gain_x32), .prescale_div2_o(presc),
    .vch_en_o(vch), .mode_chg_o(chg)
  );

  initial begin
    int cnt = 0;
    forever begin
      @(negedge clk);
      if (mclk_run) begin
        cnt++;
        if (cnt >= MHALF) begin cnt = 0; mclk = ~mclk; end
      end
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic set_mode(input int m);
    sel = m;
    if (m != model_mode) exp_q.push_back(m);
    model_mode = m;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // monitor: every strobe must match the next expected mode
  always @(negedge clk) begin
    if (rst_n && chg) begin
      if (exp_q.size() == 0) check(0, "R5 unexpected strobe", trim, -1);
      else begin
        int e;
        e = exp_q.pop_front();
        check(trim == e[1:0], "R3 strobe trim", trim, e);
      end
    end
  end

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    gain_pin = 1; sel = 3; mclk_run = 1;
    wait_cyc(10);
    check(trim == 2'd0, "R1 trim in reset", trim, 0);
    check(gain_x32 == 0, "R1 gain in reset", gain_x32, 0);
    check(vch == 0, "R1 vch in reset", vch, 0);
    check(chg == 0 && presc == 0, "R1 strobe/presc in reset", chg, 0);
    rst_n = 1;
    set_mode(3);
    wait_cyc(24);
    check(trim == 2'd0, "R4 hold before qualify", trim, 0);
    check(vch == 0, "R1 vch before lock", vch, 0);
    wait_cyc(SETTLE);
    check(trim == 2'd3, "R3 tied high", trim, 3);
    check(vch == 1, "R7 vch after lock", vch, 1);
    check(presc == 0, "R6 presc mode3", presc, 0);
    check(gain_x32 == 1, "R2 gain x32", gain_x32, 1);

    set_mode(1);
    wait_cyc(24);
    check(trim == 2'd3, "R4 hold during qualify", trim, 3);
    wait_cyc(SETTLE);
    check(trim == 2'd1, "R3 tied to clock", trim, 1);
    check(presc == 1, "R6 presc mode1", presc, 1);

    set_mode(2);
    wait_cyc(SETTLE);
    check(trim == 2'd2, "R3 tied to inverted clock", trim, 2);
    check(presc == 1, "R6 presc mode2", presc, 1);

    set_mode(0);
    wait_cyc(SETTLE);
    check(trim == 2'd0, "R3 tied low", trim, 0);
    check(presc == 0, "R6 presc mode0", presc, 0);
    check(vch == 1, "R7 vch sticky", vch, 1);

    gain_pin = 0;
    wait_cyc(5);
    check(gain_x32 == 0, "R2 gain x8", gain_x32, 0);

    // short runs never reach the qualification count
    for (int k = 0; k < 8; k++) begin
      sel = (k % 2 == 0) ? 3 : 0;
      wait_cyc(2 * MHALF * 2);
    end
    sel = 0;
    wait_cyc(SETTLE);
    check(trim == 2'd0, "R4 short runs ignored", trim, 0);

    // stopped clock: constant-level fallback
    mclk_run = 0; mclk = 0;
    set_mode(3);
    wait_cyc(4 * TMO + 80);
    check(trim == 2'd3, "R8 stalled high", trim, 3);
    set_mode(0);
    wait_cyc(4 * TMO + 80);
    check(trim == 2'd0, "R8 stalled low", trim, 0);
    mclk_run = 1;
    wait_cyc(SETTLE);
    check(trim == 2'd0, "R8 clock restart low", trim, 0);

    // reset partway through
    set_mode(2);
    wait_cyc(SETTLE);
    check(trim == 2'd2, "R3 before mid reset", trim, 2);
    rst_n = 0;
    wait_cyc(3);
    check(trim == 2'd0 && vch == 0, "R1 mid reset", trim, 0);
    exp_q.delete();
    model_mode = 0;
    sel = 0;
    rst_n = 1;
    wait_cyc(SETTLE);
    check(trim == 2'd0 && vch == 1, "R7 relock to mode0", vch, 1);
    check(exp_q.size() == 0, "R5 all strobes seen", exp_q.size(), 0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule